// File: doc/BRIEF.md
# IOMMU Context Register Bank

This block holds the software-visible registers for a set of address-translation contexts in an I/O memory management unit. Each context has a control word, a fault status word, a latched fault address, and plain configuration words for the translation-table base, the translation control and the memory attributes. A 32-bit register bus with single-cycle strobes reaches all of them. Reads return data one cycle later, together with a valid pulse.

A stub translation engine reports faults against a context. The block records the fault flags and the faulting address, and it drives one combined interrupt line. A TLB flush requested through the control word is modelled as a countdown. The flush bit stays set for a fixed number of cycles and then clears itself, and software polls it for completion.

A second bank holds one control word and one address-space identifier per requester. Each control word chooses the context that requester uses. A lookup port returns the chosen context and the enable bit for a given requester id.

Top module: `iommu_ctx_bank`

## Requirements
- R1: The window of context c starts at byte address c·0x40 for c < 8 and at 0x800 + (c−8)·0x40 for c ≥ 8. Inside a window, control is at +0x00, translation control at +0x08, table base low at +0x10, table base high at +0x14, status at +0x20, attributes at +0x28, fault address low at +0x30 and fault address high at +0x34.
- R2: The translation-control, table-base-low and attribute words read back exactly what was written. Table base high keeps only bits 7:0 and reads zero above them.
- R3: In the control word, bit 0 is translation enable and bit 2 is interrupt enable. Both read back as written, and bits 31:3 read zero.
- R4: Writing 1 to control bit 1 starts a flush. The bit then reads 1 for FLUSH_LAT cycles after the write edge and 0 afterwards. Writing 0 to bit 1 while a flush runs does not cancel it.
- R5: A fault report sets status flags from its 5-bit flag vector. Bit 4 is multiple hit, bit 2 is walk abort, bit 1 is permission fault and bit 0 is translation fault; bit 3 is dropped. When status was clear, the report also latches its 40-bit address. Bits 31:0 of that address read at +0x30 and bits 39:32 read at +0x34.
- R6: A fault report that arrives while the status is non-zero ORs its flags into the status and leaves the latched address unchanged.
- R7: Writing the value 0 to the status word clears every flag. Writing any non-zero value leaves the status unchanged.
- R8: Both fault-address words read 0 while the status of that context is zero.
- R9: `irq` is high exactly when some context has interrupt enable set and a non-zero status.
- R10: When a status write of 0 and a fault report for the same context fall in the same cycle, the fault wins. Status becomes the new flags and the new address is latched.
- R11: The control word of requester n sits at 0x300+16·n for n < 32 and at 0x600+16·(n−32) for n ≥ 32. Bit 0 is enable and bits 7:4 select the context. The identifier word is 8 bytes above and keeps bits 7:0. The lookup port returns the enable bit and the context select for `req_id`, or 0 when the id is out of range.
- R12: The requester flush bit (bit 1 of the requester control word) is accepted on write and always reads 0.
- R13: Reads of any address not named in R1 or R11 return 0, and writes to such addresses change nothing. This includes windows of contexts and requesters beyond the configured counts.
- R14: After reset every register reads 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd_en |
| flt_valid | input | 1 | Fault report strobe |
| flt_ctx | input | 4 | Context that faulted |
| flt_flags | input | 5 | Fault flags in status bit positions |
| flt_addr | input | 40 | Faulting address |
| req_id | input | 6 | Requester id for lookup |
| req_ctx | output | 4 | Context selected for req_id |
| req_en | output | 1 | Translation enable for req_id |
| irq | output | 1 | Combined fault interrupt |

## Verification
The status clear, which is a bus write of zero, can coincide with a fault report for the same context. The bench first leaves a fault pending, then drives the zero write and a new fault report in the same clock cycle. It judges the result by reading the status back and expecting only the new flags, and by reading the low fault address and expecting the new address, not the old one. A second overlap is a control write with bit 1 clear during a running flush. The bench polls the control word on the exact cycles where the countdown should still hold the bit and where it should have released it.

// File: rtl/iommu_ctx_pkg.sv
package iommu_ctx_pkg;
   localparam int BUS_AW = 12;
   localparam int BUS_DW = 32;

   localparam logic [5:0] OFF_CTRL  = 6'h00;
   localparam logic [5:0] OFF_TCR   = 6'h08;
   localparam logic [5:0] OFF_TB_LO = 6'h10;
   localparam logic [5:0] OFF_TB_HI = 6'h14;
   localparam logic [5:0] OFF_STAT  = 6'h20;
   localparam logic [5:0] OFF_ATTR  = 6'h28;
   localparam logic [5:0] OFF_FA_LO = 6'h30;
   localparam logic [5:0] OFF_FA_HI = 6'h34;

   localparam logic [3:0] UT_OFF_CTRL = 4'h0;
   localparam logic [3:0] UT_OFF_ASID = 4'h8;

   localparam int TB_HI_W = 8;
   localparam logic [4:0] FLT_MASK = 5'b10111;

   localparam int CTRL_EN_BIT    = 0;
   localparam int CTRL_FLUSH_BIT = 1;
   localparam int CTRL_IE_BIT    = 2;
   localparam int UT_SEL_LSB     = 4;
endpackage

// File: rtl/iommu_ctx_addr_dec.sv
module iommu_ctx_addr_dec
   import iommu_ctx_pkg::*;
#(
   parameter int NUM_CTX  = 16,
   parameter int NUM_UTLB = 48,
   localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
   localparam int UT_W  = (NUM_UTLB > 1) ? $clog2(NUM_UTLB) : 1
) (
   input  logic [BUS_AW-1:0] addr,
   output logic              ctx_hit,
   output logic [CTX_W-1:0]  ctx_idx,
   output logic [5:0]        ctx_off,
   output logic              ut_hit,
   output logic [UT_W-1:0]   ut_idx,
   output logic [3:0]        ut_off
);
   int ctx_num;
   int ut_num;
   logic in_lo, in_hi, ut_lo, ut_hi;

   always_comb begin
      in_lo   = (addr[11:9] == 3'b000);
      in_hi   = (addr[11:9] == 3'b100);
      ctx_num = in_hi ? 8 + int'(addr[8:6]) : int'(addr[8:6]);
      ctx_hit = (in_lo || in_hi) && (ctx_num < NUM_CTX);
      ctx_idx = CTX_W'(ctx_num);
      ctx_off = addr[5:0];

      ut_lo  = (addr >= 12'h300) && (addr <= 12'h4FF);
      ut_hi  = (addr >= 12'h600) && (addr <= 12'h7FF);
      ut_num = ut_hi ? 32 + int'((addr - 12'h600) >> 4)
                     : int'((addr - 12'h300) >> 4);
      ut_hit = (ut_lo || ut_hi) && (ut_num < NUM_UTLB);
      ut_idx = UT_W'(ut_num);
      ut_off = addr[3:0];
   end
endmodule

// File: rtl/iommu_ctx_slice.sv
module iommu_ctx_slice
   import iommu_ctx_pkg::*;
#(
   parameter int FLUSH_LAT = 20,
   parameter int FAULT_AW  = 40
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [5:0]          off,
   input  logic [BUS_DW-1:0]   wdata,
   input  logic                flt_hit,
   input  logic [4:0]          flt_flags,
   input  logic [FAULT_AW-1:0] flt_addr,
   output logic [BUS_DW-1:0]   rd_word,
   output logic                irq_req
);
   localparam int CNT_W = $clog2(FLUSH_LAT + 1);

   logic                ie_q, en_q, flush_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [BUS_DW-1:0]   tcr_q, tb_lo_q, attr_q;
   logic [TB_HI_W-1:0]  tb_hi_q;
   logic [4:0]          stat_q, stat_base, stat_nxt, flags_in;
   logic [FAULT_AW-1:0] fa_q;
   logic [BUS_DW-1:0]   fa_hi_word;
   logic                clr, take_addr, flush_go, ctrl_we;

   assign ctrl_we  = we && (off == OFF_CTRL);
   assign flush_go = ctrl_we && wdata[CTRL_FLUSH_BIT];
   assign clr      = we && (off == OFF_STAT) && (wdata == '0);

   always_comb begin
      stat_base = clr ? 5'b0 : stat_q;
      flags_in  = flt_flags & FLT_MASK;
      stat_nxt  = stat_base;
      take_addr = 1'b0;
      if (flt_hit && (flags_in != 5'b0)) begin
         stat_nxt  = stat_base | flags_in;
         take_addr = (stat_base == 5'b0);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ie_q    <= 1'b0;
         en_q    <= 1'b0;
         flush_q <= 1'b0;
         cnt_q   <= '0;
         tcr_q   <= '0;
         tb_lo_q <= '0;
         tb_hi_q <= '0;
         attr_q  <= '0;
         stat_q  <= '0;
         fa_q    <= '0;
      end else begin
         if (ctrl_we) begin
            ie_q <= wdata[CTRL_IE_BIT];
            en_q <= wdata[CTRL_EN_BIT];
         end
         if (flush_go) begin
            flush_q <= 1'b1;
            cnt_q   <= CNT_W'(FLUSH_LAT);
         end else if (flush_q) begin
            if (cnt_q <= CNT_W'(1)) begin
               flush_q <= 1'b0;
               cnt_q   <= '0;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
         if (we && off == OFF_TCR)   tcr_q   <= wdata;
         if (we && off == OFF_TB_LO) tb_lo_q <= wdata;
         if (we && off == OFF_TB_HI) tb_hi_q <= wdata[TB_HI_W-1:0];
         if (we && off == OFF_ATTR)  attr_q  <= wdata;
         stat_q <= stat_nxt;
         if (take_addr) fa_q <= flt_addr;
      end
   end

   generate
      if (FAULT_AW > 32) begin : g_fa_hi
         assign fa_hi_word = BUS_DW'(fa_q[FAULT_AW-1:32]);
      end else begin : g_fa_none
         assign fa_hi_word = '0;
      end
   endgenerate

   always_comb begin
      case (off)
         OFF_CTRL:  rd_word = BUS_DW'({ie_q, flush_q, en_q});
         OFF_TCR:   rd_word = tcr_q;
         OFF_TB_LO: rd_word = tb_lo_q;
         OFF_TB_HI: rd_word = BUS_DW'(tb_hi_q);
         OFF_STAT:  rd_word = BUS_DW'(stat_q);
         OFF_ATTR:  rd_word = attr_q;
         OFF_FA_LO: rd_word = (stat_q != 5'b0) ? fa_q[31:0] : '0;
         OFF_FA_HI: rd_word = (stat_q != 5'b0) ? fa_hi_word : '0;
         default:   rd_word = '0;
      endcase
   end

   assign irq_req = ie_q && (stat_q != 5'b0);

   assert_flush_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_q && cnt_q > CNT_W'(1)) |=> flush_q);
   assert_flush_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_q && cnt_q == CNT_W'(1) && !flush_go) |=> !flush_q);
   assert_addr_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q != 5'b0 && !clr) |=> $stable(fa_q));
   assert_stat_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q != 5'b0 && !clr) |=> (stat_q != 5'b0));
   assert_stat_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !flt_hit) |=> (stat_q == 5'b0));
endmodule

// File: rtl/iommu_utlb_bank.sv
module iommu_utlb_bank
   import iommu_ctx_pkg::*;
#(
   parameter int NUM_UTLB = 48,
   parameter int SEL_W    = 4,
   parameter int ASID_W   = 8,
   localparam int UT_W = (NUM_UTLB > 1) ? $clog2(NUM_UTLB) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [UT_W-1:0]   idx,
   input  logic [3:0]        off,
   input  logic [BUS_DW-1:0] wdata,
   output logic [BUS_DW-1:0] rd_word,
   input  logic [UT_W-1:0]   look_id,
   output logic [SEL_W-1:0]  look_ctx,
   output logic              look_en
);
   logic              en_q   [NUM_UTLB];
   logic [SEL_W-1:0]  sel_q  [NUM_UTLB];
   logic [ASID_W-1:0] asid_q [NUM_UTLB];

   for (genvar n = 0; n < NUM_UTLB; n++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            en_q[n]   <= 1'b0;
            sel_q[n]  <= '0;
            asid_q[n] <= '0;
         end else if (we && idx == UT_W'(n)) begin
            if (off == UT_OFF_CTRL) begin
               en_q[n]  <= wdata[CTRL_EN_BIT];
               sel_q[n] <= wdata[UT_SEL_LSB +: SEL_W];
            end
            if (off == UT_OFF_ASID) asid_q[n] <= wdata[ASID_W-1:0];
         end
      end
   end

   always_comb begin
      rd_word = '0;
      if (int'(idx) < NUM_UTLB) begin
         if (off == UT_OFF_CTRL)
            rd_word = (BUS_DW'(sel_q[idx]) << UT_SEL_LSB) | BUS_DW'(en_q[idx]);
         else if (off == UT_OFF_ASID)
            rd_word = BUS_DW'(asid_q[idx]);
      end
      look_en  = 1'b0;
      look_ctx = '0;
      if (int'(look_id) < NUM_UTLB) begin
         look_en  = en_q[look_id];
         look_ctx = sel_q[look_id];
      end
   end
endmodule

// File: rtl/iommu_ctx_bank.sv
module iommu_ctx_bank
   import iommu_ctx_pkg::*;
#(
   parameter int NUM_CTX   = 16,
   parameter int NUM_UTLB  = 48,
   parameter int FLUSH_LAT = 20,
   parameter int FAULT_AW  = 40,
   parameter int SEL_W     = 4,
   parameter int ASID_W    = 8,
   localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
   localparam int UT_W  = (NUM_UTLB > 1) ? $clog2(NUM_UTLB) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr_en,
   input  logic                bus_rd_en,
   input  logic [BUS_AW-1:0]   bus_addr,
   input  logic [BUS_DW-1:0]   bus_wdata,
   output logic [BUS_DW-1:0]   bus_rdata,
   output logic                bus_rvalid,
   input  logic                flt_valid,
   input  logic [CTX_W-1:0]    flt_ctx,
   input  logic [4:0]          flt_flags,
   input  logic [FAULT_AW-1:0] flt_addr,
   input  logic [UT_W-1:0]     req_id,
   output logic [SEL_W-1:0]    req_ctx,
   output logic                req_en,
   output logic                irq
);
   generate
      if (NUM_CTX < 1 || NUM_CTX > 16) begin : g_bad_ctx
         $error("NUM_CTX must be 1..16");
      end
      if (NUM_UTLB < 1 || NUM_UTLB > 64) begin : g_bad_ut
         $error("NUM_UTLB must be 1..64");
      end
      if (FLUSH_LAT < 1) begin : g_bad_lat
         $error("FLUSH_LAT must be at least 1");
      end
      if (FAULT_AW < 32 || FAULT_AW > 64) begin : g_bad_aw
         $error("FAULT_AW must be 32..64");
      end
      if (SEL_W < CTX_W || SEL_W > 8 || ASID_W < 1 || ASID_W > 32) begin : g_bad_ut_w
         $error("requester field widths out of range");
      end
   endgenerate

   logic             ctx_hit, ut_hit;
   logic [CTX_W-1:0] ctx_idx;
   logic [5:0]       ctx_off;
   logic [UT_W-1:0]  ut_idx;
   logic [3:0]       ut_off;
   logic [BUS_DW-1:0] ctx_rd [NUM_CTX];
   logic [NUM_CTX-1:0] irq_vec;
   logic [BUS_DW-1:0] ut_rd, rd_next;

   iommu_ctx_addr_dec #(.NUM_CTX(NUM_CTX), .NUM_UTLB(NUM_UTLB)) u_dec (
      .addr(bus_addr), .ctx_hit(ctx_hit), .ctx_idx(ctx_idx), .ctx_off(ctx_off),
      .ut_hit(ut_hit), .ut_idx(ut_idx), .ut_off(ut_off));

   for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
      iommu_ctx_slice #(.FLUSH_LAT(FLUSH_LAT), .FAULT_AW(FAULT_AW)) u_slice (
         .clk(clk), .rst_n(rst_n),
         .we(bus_wr_en && ctx_hit && ctx_idx == CTX_W'(c)),
         .off(ctx_off), .wdata(bus_wdata),
         .flt_hit(flt_valid && flt_ctx == CTX_W'(c)),
         .flt_flags(flt_flags), .flt_addr(flt_addr),
         .rd_word(ctx_rd[c]), .irq_req(irq_vec[c]));
   end

   iommu_utlb_bank #(.NUM_UTLB(NUM_UTLB), .SEL_W(SEL_W), .ASID_W(ASID_W)) u_utlb (
      .clk(clk), .rst_n(rst_n), .we(bus_wr_en && ut_hit), .idx(ut_idx),
      .off(ut_off), .wdata(bus_wdata), .rd_word(ut_rd),
      .look_id(req_id), .look_ctx(req_ctx), .look_en(req_en));

   always_comb begin
      rd_next = '0;
      if (ctx_hit)     rd_next = ctx_rd[ctx_idx];
      else if (ut_hit) rd_next = ut_rd;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
      end else begin
         bus_rvalid <= bus_rd_en;
         bus_rdata  <= bus_rd_en ? rd_next : '0;
      end
   end

   assign irq = |irq_vec;

   assert_unmapped_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_en && !ctx_hit && !ut_hit) |=> (bus_rdata == '0));
   assert_rvalid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd_en |=> bus_rvalid);
endmodule

// File: tb/tb_iommu_ctx_bank.sv
`timescale 1ns/1ps
module tb_iommu_ctx_bank;
   localparam int LAT = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_rvalid;
   logic        flt_valid = 1'b0;
   logic [3:0]  flt_ctx = '0;
   logic [4:0]  flt_flags = '0;
   logic [39:0] flt_addr = '0;
   logic [5:0]  req_id = '0;
   logic [3:0]  req_ctx;
   logic        req_en;
   logic        irq;

   int vectors = 0;
   int miss = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2.5 clk = ~clk;

   iommu_ctx_bank #(.FLUSH_LAT(LAT)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid), .flt_valid(flt_valid), .flt_ctx(flt_ctx),
      .flt_flags(flt_flags), .flt_addr(flt_addr), .req_id(req_id),
      .req_ctx(req_ctx), .req_en(req_en), .irq(irq));

   function automatic logic [11:0] win(input int c);
      return (c < 8) ? 12'(c * 64) : 12'(12'h800 + (c - 8) * 64);
   endfunction

   function automatic logic [11:0] utc(input int n);
      return (n < 32) ? 12'(12'h300 + 16 * n) : 12'(12'h600 + 16 * (n - 32));
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miss++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read data as the design returns it
   always @(negedge clk) begin
      if (rst_n && bus_rvalid) begin
         if (exp_q.size() == 0) begin
            check("R1 unexpected read return", bus_rdata, 32'hxxxx_xxxx);
         end else begin
            automatic logic [31:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(t, bus_rdata, e);
         end
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
      bus_rd_en = 1'b1; bus_addr = a;
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk);
      bus_rd_en = 1'b0;
   endtask

   task automatic fault(input int c, input logic [4:0] f, input logic [39:0] a);
      flt_valid = 1'b1; flt_ctx = 4'(c); flt_flags = f; flt_addr = a;
      @(negedge clk);
      flt_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
   endtask

   initial begin
      #(5ns * 20000);
      miss++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R14 reset state
      check("R14 irq after reset", 32'(irq), 32'h0);
      rd(win(0) + 12'h00, 32'h0, "R14 ctrl ctx0 reset");
      rd(win(15) + 12'h20, 32'h0, "R14 status ctx15 reset");
      rd(utc(5), 32'h0, "R14 requester ctrl reset");

      // R2 plain registers
      wr(win(0) + 12'h08, 32'h8000_0080);
      wr(win(3) + 12'h14, 32'hFFFF_FFA5);
      wr(win(9) + 12'h28, 32'hDEAD_BEEF);
      rd(win(0) + 12'h08, 32'h8000_0080, "R2 translation control");
      rd(win(3) + 12'h14, 32'h0000_00A5, "R2 table base high");
      rd(win(9) + 12'h28, 32'hDEAD_BEEF, "R2 attributes");

      // R1 window placement across both regions
      wr(win(7) + 12'h10, 32'h7777_0007);
      wr(win(8) + 12'h10, 32'h8888_0008);
      wr(win(15) + 12'h10, 32'hFFFF_000F);
      rd(12'h1D0, 32'h7777_0007, "R1 ctx7 table base");
      rd(12'h810, 32'h8888_0008, "R1 ctx8 table base");
      rd(12'h9D0, 32'hFFFF_000F, "R1 ctx15 table base");
      rd(12'h210, 32'h0, "R13 gap after ctx7");

      // R3 control bits
      wr(win(2), 32'hFFFF_FFFD);
      rd(win(2), 32'h5, "R3 control readback");

      // R4 flush countdown
      wr(win(5), 32'h3);
      idle(LAT - 1);
      rd(win(5), 32'h3, "R4 flush still set");
      rd(win(5), 32'h1, "R4 flush released");
      wr(win(6), 32'h2);
      wr(win(6), 32'h0);
      idle(LAT - 2);
      rd(win(6), 32'h2, "R4 flush not cancelled");
      rd(win(6), 32'h0, "R4 flush released after cancel try");

      // R5 / R8 fault capture
      rd(win(1) + 12'h30, 32'h0, "R8 fault low before fault");
      fault(1, 5'b11001, 40'hAB_1234_5678);
      check("R9 irq low with ie clear", 32'(irq), 32'h0);
      rd(win(1) + 12'h20, 32'h11, "R5 status flags bit3 dropped");
      rd(win(1) + 12'h30, 32'h1234_5678, "R5 fault low");
      rd(win(1) + 12'h34, 32'hAB, "R5 fault high");

      // R6 second fault keeps address
      fault(1, 5'b00010, 40'h11_0000_0000);
      rd(win(1) + 12'h20, 32'h13, "R6 flags merged");
      rd(win(1) + 12'h30, 32'h1234_5678, "R6 address kept");

      // R9 interrupt enable
      wr(win(1), 32'h4);
      check("R9 irq with ie and status", 32'(irq), 32'h1);

      // R7 clear semantics
      wr(win(1) + 12'h20, 32'h13);
      rd(win(1) + 12'h20, 32'h13, "R7 nonzero write ignored");
      wr(win(1) + 12'h20, 32'h0);
      check("R9 irq drops after clear", 32'(irq), 32'h0);
      rd(win(1) + 12'h20, 32'h0, "R7 status cleared");
      rd(win(1) + 12'h30, 32'h0, "R8 fault low after clear");
      rd(win(1) + 12'h34, 32'h0, "R8 fault high after clear");
      fault(12, 5'b00001, 40'h1);
      check("R9 irq low for ctx without ie", 32'(irq), 32'h0);

      // R10 clear and fault in same cycle
      fault(1, 5'b00001, 40'h33_0000_0001);
      flt_valid = 1'b1; flt_ctx = 4'd1; flt_flags = 5'b00100; flt_addr = 40'h22_CAFE_0000;
      wr(win(1) + 12'h20, 32'h0);
      flt_valid = 1'b0;
      rd(win(1) + 12'h20, 32'h04, "R10 fault wins status");
      rd(win(1) + 12'h30, 32'hCAFE_0000, "R10 fault wins address");
      check("R10 irq stays with new fault", 32'(irq), 32'h1);

      // R11 / R12 requester bank
      wr(utc(5), 32'h0000_00B1);
      wr(utc(40), 32'h0000_00C3);
      wr(utc(40) + 12'h8, 32'h0000_01FF);
      wr(utc(31), 32'h0000_0071);
      rd(12'h350, 32'hB1, "R11 requester5 ctrl");
      rd(12'h680, 32'hC1, "R12 flush bit reads zero");
      rd(12'h688, 32'hFF, "R11 requester40 id");
      rd(12'h4F0, 32'h71, "R11 requester31 ctrl");
      req_id = 6'd40; #1;
      check("R11 lookup ctx 40", 32'(req_ctx), 32'hC);
      check("R11 lookup en 40", 32'(req_en), 32'h1);
      req_id = 6'd5; #1;
      check("R11 lookup ctx 5", 32'(req_ctx), 32'hB);
      req_id = 6'd47; #1;
      check("R11 lookup en 47", 32'(req_en), 32'h0);
      req_id = 6'd50; #1;
      check("R11 lookup out of range", 32'(req_en), 32'h0);
      @(negedge clk);

      // R13 unmapped space
      wr(12'h20C, 32'hFFFF_FFFF);
      wr(win(0) + 12'h04, 32'h1234_5678);
      wr(12'h7F0, 32'h0000_00F1);
      rd(12'h20C, 32'h0, "R13 unmapped gap");
      rd(win(0) + 12'h04, 32'h0, "R13 unused window slot");
      rd(12'h7F0, 32'h0, "R13 requester beyond count");
      rd(win(0) + 12'h08, 32'h8000_0080, "R13 neighbour untouched");

      idle(3);
      check("R1 all reads returned", 32'(exp_q.size()), 32'h0);
      finish_run();
   end
endmodule